// File: doc/BRIEF.md
# Serial Port Register and Interrupt Unit

This block is the register front end of a simple serial port. A processor reaches it through a synchronous 32-bit word bus with one cycle of read latency. Bytes that arrive on a valid/ready byte stream are stored in a 16-entry receive queue. Software reads them back through two status words. Both status words return the oldest queued byte together with flag bits. One of the two words also removes that byte from the queue, and the other only looks at it. A write to the data-out word sends the low byte on a transmit stream as a one-cycle pulse.

Interrupts are kept in three registers: raw, mask and masked. Software acknowledges raw bits by writing ones to the acknowledge word. One raw bit follows the queue occupancy at all times. The transmit-done bit has an exception: the first acknowledge after a transmit cannot clear it. The single interrupt output is high whenever any masked bit is set. Every other word inside the window is plain read/write storage.

Top module: `serial_regif`

## Requirements
- R1: During and after synchronous reset the unit is in this state: `irq`, `tx_valid` and `rx_ready` are low, the queue is empty, the raw and mask registers read 0, and the receive control word (offset 0x08) reads 0x00010000.
- R2: A read at offset 0x20 or 0x24 returns a status word in the next cycle. Bits 7:0 hold the oldest queued byte and are meaningful only when the queue is non-empty. Bit 16 is 1 exactly when the queue is non-empty. Bits 22 and 24 are always 1. All other bits are 0.
- R3: A read at offset 0x24 leaves the queue contents and occupancy unchanged.
- R4: A read at offset 0x20 removes the oldest byte when the queue is non-empty, so bytes come out in arrival order. On an empty queue it has no effect.
- R5: `rx_ready` is high only while bit 3 of the receive control word (offset 0x08) is 1. A byte offered while `rx_ready` is low is not stored.
- R6: The queue holds 16 bytes. When it is full, `rx_ready` is low and a further offered byte is discarded.
- R7: A write at offset 0x1C produces `tx_valid` high for exactly one cycle, starting on the following cycle, with `tx_data` equal to bits 7:0 of the written word. The same write sets raw interrupt bits 0 and 1 and arms a pending-transmit flag.
- R8: A write at offset 0x30 clears every raw interrupt bit written as 1. If the pending-transmit flag is armed, bit 0 is first removed from the written value, and the flag is disarmed.
- R9: Raw interrupt bit 3 (read at offset 0x34) is 1 exactly when the queue is non-empty, whatever value is written to the raw word.
- R10: The masked word (offset 0x38) reads the raw word ANDed with the mask word (offset 0x2C). `irq` is high exactly when that result is non-zero.
- R11: When a pop at offset 0x20 and an accepted incoming byte fall in the same cycle, the occupancy is unchanged and the order of the bytes is kept.
- R12: The words at offsets 0x00, 0x04, 0x0C to 0x18, 0x1C and 0x28 read back the last value written to them. Writes to offsets 0x20, 0x24 and 0x38 have no effect. A read at offset 0x3C returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address of the accessed word; bits 1:0 are ignored |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| rx_valid | input | 1 | Incoming byte is offered |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Unit accepts the offered byte in this cycle |
| tx_valid | output | 1 | One-cycle pulse carrying a transmit byte |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is a pop and an accepted byte landing on the same clock edge. The bench gets there by holding `rx_valid` with a new byte in the same cycle that it strobes a read of the popping status word. It then drains the queue and checks that the order is intact. The full-queue boundary is reached by offering sixteen bytes in a row and then a seventeenth. The acknowledge fix-up for the transmit-done bit needs a transmit followed by two separate acknowledge writes, and the bench checks the raw word between them.

// File: rtl/serial_regif_pkg.sv
package serial_regif_pkg;

  localparam int ADDR_W    = 6;
  localparam int IDX_W     = ADDR_W - 2;
  localparam int WORD_W    = 32;
  localparam int BYTE_W    = 8;
  localparam int WIN_WORDS = 15;   // window spans 0x00..0x38

  // word indices (byte offset / 4); software depends on these positions
  localparam logic [IDX_W-1:0] W_TXCTRL = 4'd0;
  localparam logic [IDX_W-1:0] W_RXCTRL = 4'd2;
  localparam logic [IDX_W-1:0] W_DOUT   = 4'd7;
  localparam logic [IDX_W-1:0] W_POP    = 4'd8;
  localparam logic [IDX_W-1:0] W_PEEK   = 4'd9;
  localparam logic [IDX_W-1:0] W_MASK   = 4'd11;
  localparam logic [IDX_W-1:0] W_ACK    = 4'd12;
  localparam logic [IDX_W-1:0] W_RAW    = 4'd13;
  localparam logic [IDX_W-1:0] W_MASKED = 4'd14;

  // status word flag positions
  localparam int ST_AVAIL  = 16;
  localparam int ST_TXIDLE = 22;
  localparam int ST_TXRDY  = 24;

  localparam int RXEN_BIT     = 3;
  localparam int RAW_RX_BIT   = 3;
  localparam logic [WORD_W-1:0] RXCTRL_RST = 32'h0001_0000;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // words that are held in the plain storage bank
  function automatic bit is_plain(int i);
    return !(i == int'(W_POP)  || i == int'(W_PEEK) || i == int'(W_MASK) ||
             i == int'(W_ACK)  || i == int'(W_RAW)  || i == int'(W_MASKED));
  endfunction

  function automatic word_t plain_reset(int i);
    return (i == int'(W_RXCTRL)) ? RXCTRL_RST : '0;
  endfunction

  function automatic word_t make_status(byte_t head, logic avail);
    word_t s;
    s            = '0;
    s[BYTE_W-1:0] = head;
    s[ST_AVAIL]  = avail;
    s[ST_TXIDLE] = 1'b1;
    s[ST_TXRDY]  = 1'b1;
    return s;
  endfunction

endpackage

// File: rtl/sr_word_store.sv
module sr_word_store
  import serial_regif_pkg::*;
#(
  parameter int N_WORDS = WIN_WORDS,
  parameter int IW      = IDX_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [IW-1:0]               wr_idx,
  input  word_t                       wdata,
  output logic [N_WORDS-1:0][WORD_W-1:0] words
);

  for (genvar i = 0; i < N_WORDS; i++) begin : g_word
    if (is_plain(i)) begin : g_store
      word_t q;
      always_ff @(posedge clk) begin
        if (rst)
          q <= plain_reset(i);
        else if (wr_en && (wr_idx == IW'(i)))
          q <= wdata;
      end
      assign words[i] = q;
    end else begin : g_none
      assign words[i] = '0;
    end
  end

endmodule

// File: rtl/sr_rx_queue.sv
module sr_rx_queue #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count,
  output logic          nonempty_nxt
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_nxt;
  logic          do_push, do_pop;

  assign do_push   = push && !full;
  assign do_pop    = pop && !empty;
  assign count_nxt = count + CW'(do_push) - CW'(do_pop);

  // data array has no reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (do_push)
      mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + PW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + PW'(1);
      count <= count_nxt;
    end
  end

  assign head_data    = mem[rd_ptr];
  assign empty        = (count == '0);
  assign full         = (count == CW'(DEPTH));
  assign nonempty_nxt = (count_nxt != '0);

endmodule

// File: rtl/sr_irq_ctrl.sv
module sr_irq_ctrl
  import serial_regif_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_mask,
  input  logic  wr_ack,
  input  logic  wr_raw,
  input  logic  tx_fire,
  input  word_t wdata,
  input  logic  rx_nonempty_nxt,
  output word_t raw_q,
  output word_t mask_q,
  output word_t ack_q,
  output word_t masked,
  output logic  irq_o
);

  word_t raw_n, mask_n, ack_n, ack_eff;
  logic  pend_q, pend_n;

  always_comb begin
    raw_n   = raw_q;
    mask_n  = mask_q;
    ack_n   = ack_q;
    pend_n  = pend_q;
    ack_eff = wdata;
    if (wr_raw)  raw_n  = wdata;
    if (wr_mask) mask_n = wdata;
    if (tx_fire) begin
      raw_n[1:0] = 2'b11;
      pend_n     = 1'b1;
    end
    if (wr_ack) begin
      if (pend_q) ack_eff[0] = 1'b0;
      pend_n = 1'b0;
      raw_n  = raw_n & ~ack_eff;
      ack_n  = ack_eff;
    end
    raw_n[RAW_RX_BIT] = rx_nonempty_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
      ack_q  <= '0;
      pend_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      raw_q  <= raw_n;
      mask_q <= mask_n;
      ack_q  <= ack_n;
      pend_q <= pend_n;
      irq_o  <= |(raw_n & mask_n);
    end
  end

  assign masked = raw_q & mask_q;

endmodule

// File: rtl/serial_regif.sv
module serial_regif
  import serial_regif_pkg::*;
#(
  parameter int QDEPTH = 16,
  localparam int QCW   = $clog2(QDEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              irq
);

  localparam logic [IDX_W-1:0] WIN_END = IDX_W'(WIN_WORDS);

  logic [IDX_W-1:0] w_idx;
  logic             unused_lsb;
  logic             in_win, wr_hit, rd_hit;
  logic             q_push, q_pop, q_empty, q_full, q_nonempty_nxt, rx_en;
  logic [QCW-1:0]   q_count;
  byte_t            q_head;
  word_t            irq_raw, irq_mask, irq_ack, irq_masked, rd_mux;
  logic [WIN_WORDS-1:0][WORD_W-1:0] store_words;

  assign w_idx      = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];
  assign in_win     = (w_idx < WIN_END);
  assign wr_hit     = bus_wr && in_win;
  assign rd_hit     = bus_rd && in_win;

  assign rx_en    = store_words[W_RXCTRL][RXEN_BIT];
  assign rx_ready = rx_en && !q_full;
  assign q_push   = rx_valid && rx_ready;
  assign q_pop    = rd_hit && (w_idx == W_POP) && !q_empty;

  sr_word_store #(.N_WORDS(WIN_WORDS), .IW(IDX_W)) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_hit),
    .wr_idx (w_idx),
    .wdata  (bus_wdata),
    .words  (store_words)
  );

  sr_rx_queue #(.DEPTH(QDEPTH), .DW(BYTE_W)) u_rxq (
    .clk          (clk),
    .rst          (rst),
    .push         (q_push),
    .push_data    (rx_data),
    .pop          (q_pop),
    .head_data    (q_head),
    .empty        (q_empty),
    .full         (q_full),
    .count        (q_count),
    .nonempty_nxt (q_nonempty_nxt)
  );

  sr_irq_ctrl u_irq (
    .clk             (clk),
    .rst             (rst),
    .wr_mask         (wr_hit && (w_idx == W_MASK)),
    .wr_ack          (wr_hit && (w_idx == W_ACK)),
    .wr_raw          (wr_hit && (w_idx == W_RAW)),
    .tx_fire         (wr_hit && (w_idx == W_DOUT)),
    .wdata           (bus_wdata),
    .rx_nonempty_nxt (q_nonempty_nxt),
    .raw_q           (irq_raw),
    .mask_q          (irq_mask),
    .ack_q           (irq_ack),
    .masked          (irq_masked),
    .irq_o           (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (in_win) begin
      case (w_idx)
        W_POP, W_PEEK: rd_mux = make_status(q_head, !q_empty);
        W_MASK:        rd_mux = irq_mask;
        W_ACK:         rd_mux = irq_ack;
        W_RAW:         rd_mux = irq_raw;
        W_MASKED:      rd_mux = irq_masked;
        default:       rd_mux = store_words[w_idx];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      tx_valid <= wr_hit && (w_idx == W_DOUT);
      if (wr_hit && (w_idx == W_DOUT)) tx_data <= bus_wdata[7:0];
    end
  end

endmodule

// File: rtl/serial_regif_chk.sv
module serial_regif_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [5:0]    bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [31:0]   bus_wdata,
  input logic          rx_ready,
  input logic          tx_valid,
  input logic [7:0]    tx_data,
  input logic          irq,
  input logic          q_push,
  input logic          q_pop,
  input logic          rx_en,
  input logic [CW-1:0] q_count,
  input logic [31:0]   irq_raw,
  input logic [31:0]   irq_mask
);

  logic dout_wr;
  assign dout_wr = bus_wr && (bus_addr[5:2] == 4'd7);

  a_r7_tx_pulse: assert property (@(posedge clk) disable iff (rst)
    dout_wr |=> (tx_valid && tx_data == $past(bus_wdata[7:0])));

  a_r7_no_spurious_tx: assert property (@(posedge clk) disable iff (rst)
    !dout_wr |=> !tx_valid);

  a_r6_occupancy_bound: assert property (@(posedge clk) disable iff (rst)
    q_count <= CW'(DEPTH));

  a_r6_full_blocks: assert property (@(posedge clk) disable iff (rst)
    (q_count == CW'(DEPTH)) |-> !rx_ready);

  a_r5_disabled_blocks: assert property (@(posedge clk) disable iff (rst)
    !rx_en |-> !rx_ready);

  a_r11_push_pop_keep: assert property (@(posedge clk) disable iff (rst)
    (q_push && q_pop) |=> (q_count == $past(q_count)));

  a_r3_peek_keeps: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[5:2] == 4'd9 && !q_push) |=> (q_count == $past(q_count)));

  a_r9_rx_bit_tracks: assert property (@(posedge clk) disable iff (rst)
    irq_raw[3] == (q_count != '0));

  a_r10_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq == (|(irq_raw & irq_mask)));

endmodule

bind serial_regif serial_regif_chk #(.DEPTH(QDEPTH), .CW(QCW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .rx_ready  (rx_ready),
  .tx_valid  (tx_valid),
  .tx_data   (tx_data),
  .irq       (irq),
  .q_push    (q_push),
  .q_pop     (q_pop),
  .rx_en     (rx_en),
  .q_count   (q_count),
  .irq_raw   (irq_raw),
  .irq_mask  (irq_mask)
);

// File: tb/serial_regif_tb.sv
module serial_regif_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] FLAGS = 32'h0140_0000;  // bits 24 and 22
  localparam logic [31:0] AVAIL = 32'h0001_0000;  // bit 16

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid, irq;
  logic [7:0]  tx_data;

  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;
  logic       seen_tx_v;
  logic [7:0] seen_tx_d;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_regif u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    seen_tx_v = tx_valid;
    seen_tx_d = tx_data;
  endtask

  task automatic bus_read(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic push_byte(logic [7:0] b, output logic taken);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    #1 taken = rx_ready;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 tx_valid", {31'b0, tx_valid}, 0);
    check("R1 rx_ready", {31'b0, rx_ready}, 0);
    bus_read(6'h08, r); check("R1 rx control", r, 32'h0001_0000);
    bus_read(6'h34, r); check("R1 raw", r, 0);
    bus_read(6'h2C, r); check("R1 mask", r, 0);
    bus_read(6'h24, r); check("R1/R2 empty status", r & 32'hFFFF_FF00, FLAGS);
  endtask

  task automatic t_disabled();
    logic t; logic [31:0] r;
    push_byte(8'h5A, t);
    check("R5 ready low while disabled", {31'b0, t}, 0);
    bus_read(6'h24, r); check("R5 nothing stored", r & 32'hFFFF_FF00, FLAGS);
  endtask

  task automatic t_fifo();
    logic t; logic [31:0] r;
    bus_write(6'h08, 32'h8);
    check("R5 ready high once enabled", {31'b0, rx_ready}, 1);
    push_byte(8'hA1, t); push_byte(8'hB2, t); push_byte(8'hC3, t);
    bus_read(6'h24, r); check("R2 peek format", r, FLAGS | AVAIL | 32'hA1);
    bus_read(6'h24, r); check("R3 peek again same byte", r, FLAGS | AVAIL | 32'hA1);
    bus_read(6'h34, r); check("R9 raw bit3 set", r, 32'h8);
    bus_read(6'h20, r); check("R4 pop first", r, FLAGS | AVAIL | 32'hA1);
    bus_read(6'h20, r); check("R4 pop second", r, FLAGS | AVAIL | 32'hB2);
    bus_read(6'h20, r); check("R4 pop third", r, FLAGS | AVAIL | 32'hC3);
    bus_read(6'h20, r); check("R4 pop empty", r & 32'hFFFF_FF00, FLAGS);
    bus_read(6'h34, r); check("R9 raw bit3 clear", r, 0);
  endtask

  task automatic t_full();
    logic t; logic [31:0] r;
    for (int i = 0; i < 16; i++) begin
      push_byte(8'h10 + 8'(i), t);
      check("R6 accept below capacity", {31'b0, t}, 1);
    end
    check("R6 ready low when full", {31'b0, rx_ready}, 0);
    push_byte(8'hEE, t);
    check("R6 seventeenth refused", {31'b0, t}, 0);
    for (int i = 0; i < 16; i++) begin
      bus_read(6'h20, r);
      check("R6 drain order", r, FLAGS | AVAIL | (32'h10 + 32'(i)));
    end
    bus_read(6'h24, r); check("R6 dropped byte absent", r & 32'hFFFF_FF00, FLAGS);
  endtask

  task automatic t_simul();
    logic t; logic [31:0] r;
    push_byte(8'h31, t); push_byte(8'h32, t);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h55; bus_addr = 6'h20; bus_rd = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; bus_rd = 1'b0; r = bus_rdata;
    check("R11 pop during push", r, FLAGS | AVAIL | 32'h31);
    bus_read(6'h20, r); check("R11 next", r, FLAGS | AVAIL | 32'h32);
    bus_read(6'h20, r); check("R11 pushed byte", r, FLAGS | AVAIL | 32'h55);
    bus_read(6'h20, r); check("R11 empty after", r & 32'hFFFF_FF00, FLAGS);
  endtask

  task automatic t_tx_irq();
    logic t; logic [31:0] r;
    bus_write(6'h2C, 32'hB);
    bus_write(6'h1C, 32'h1234_5678);
    check("R7 tx pulse", {31'b0, seen_tx_v}, 1);
    check("R7 tx byte", {24'b0, seen_tx_d}, 32'h78);
    @(negedge clk);
    check("R7 pulse one cycle", {31'b0, tx_valid}, 0);
    bus_read(6'h34, r); check("R7 raw bits 0,1", r, 32'h3);
    bus_read(6'h38, r); check("R10 masked", r, 32'h3);
    check("R10 irq high", {31'b0, irq}, 1);
    bus_write(6'h30, 32'h3);
    bus_read(6'h34, r); check("R8 first ack keeps bit0", r, 32'h1);
    bus_write(6'h30, 32'h1);
    bus_read(6'h34, r); check("R8 second ack clears", r, 0);
    check("R10 irq low", {31'b0, irq}, 0);
    bus_write(6'h2C, 32'h0);
    bus_write(6'h1C, 32'hAB);
    bus_read(6'h38, r); check("R10 masked zero", r, 0);
    check("R10 irq masked off", {31'b0, irq}, 0);
    bus_write(6'h30, 32'h3); bus_write(6'h30, 32'h3);
    bus_write(6'h2C, 32'h8);
    push_byte(8'h77, t);
    check("R9 irq from queue", {31'b0, irq}, 1);
    bus_read(6'h20, r);
    check("R9 irq drops on empty", {31'b0, irq}, 0);
    bus_write(6'h2C, 32'h0);
  endtask

  task automatic t_storage();
    logic [31:0] r;
    bus_write(6'h0C, 32'hDEAD_BEEF);
    bus_write(6'h28, 32'h1234_5678);
    bus_write(6'h00, 32'hCAFE_0001);
    bus_read(6'h0C, r); check("R12 word 0x0C", r, 32'hDEAD_BEEF);
    bus_read(6'h28, r); check("R12 word 0x28", r, 32'h1234_5678);
    bus_read(6'h00, r); check("R12 word 0x00", r, 32'hCAFE_0001);
    bus_read(6'h1C, r); check("R12 data-out word", r, 32'hAB);
    bus_write(6'h24, 32'hFFFF_FFFF);
    bus_read(6'h24, r); check("R12 status write ignored", r & 32'hFFFF_FF00, FLAGS);
    bus_write(6'h38, 32'hFFFF_FFFF);
    bus_read(6'h38, r); check("R12 masked write ignored", r, 0);
    bus_read(6'h3C, r); check("R12 outside window", r, 0);
    bus_write(6'h34, 32'hC);
    bus_read(6'h34, r); check("R9 raw write bit3 forced", r, 32'h4);
    bus_write(6'h30, 32'h4);
    bus_read(6'h34, r); check("R8 ack clears written bit", r, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {31'b0, irq}, 0);
    rst = 1'b0;
    t_reset();
    t_disabled();
    t_fifo();
    t_full();
    t_simul();
    t_tx_irq();
    t_storage();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule